// File: doc/BRIEF.md
# Pipelined Sine and Cosine Rotator

This block turns a signed fixed-point angle into its sine and cosine and accepts a new angle every clock cycle. The angle is a W-bit two's-complement fraction in half-turns, so code `x` stands for the angle `pi * x / 2^(W-1)` radians. The range [-1, 1) covers one full turn, and integer bits that a caller drops wrap naturally. Each result is a pair of W-bit signed fractions with W-1 fraction bits. Both are scaled by `(1 - 2^-(W-1))`, so a full-scale value becomes the largest positive code and can never overflow.

The three leading angle bits pick the half-turn, the quarter and the eighth. The angle is folded into [0, 1/4] and run through a chain of shift-and-add micro-rotations, one pipeline register per rotation, on a datapath widened by guard bits. The pair is then rounded to W bits, and sine and cosine are swapped and negated according to the three leading bits. The residual-angle path loses one bit of width per rotation. A valid flag travels with each angle, so idle cycles are allowed and results leave in the order the angles arrived.

Top module: `sincos_cordic_pipe`

## Requirements
- R1: While reset is asserted, and after its release until the first accepted angle has crossed the pipeline, `res_vld` is low.
- R2: An angle accepted with `ang_vld` high yields exactly one result, with `res_vld` high, W+3 cycles later. Back-to-back angles give back-to-back results in the same order, and idle input cycles yield no result.
- R3: For every input code, `sin_out` and `cos_out` each differ from `(2^(W-1) - 1) * sin(pi*x)` and `(2^(W-1) - 1) * cos(pi*x)` by less than one code (faithful rounding). Here x is the input code divided by 2^(W-1).
- R4: Neither output ever takes the code -2^(W-1). At input code 0 the pair (sin, cos) is (0, 2^(W-1)-1). At 2^(W-2) it is (2^(W-1)-1, 0). At -2^(W-1) it is (0, -(2^(W-1)-1)). At -2^(W-2) it is (-(2^(W-1)-1), 0).
- R5: Bit W-3 marks the upper eighth of a quarter. For codes a in 1..2^(W-3)-1 and b = 2^(W-2) - a, sin(b) equals cos(a) and cos(b) equals sin(a) exactly.
- R6: Bit W-2 marks the second quarter of a half-turn. For codes a in 0..2^(W-2)-1 and b = a + 2^(W-2), sin(b) equals cos(a) and cos(b) equals -sin(a) exactly.
- R7: Bit W-1 is the sign. For codes a in 0..2^(W-1)-1 and b = a + 2^(W-1) (modulo 2^W), sin(b) equals -sin(a) and cos(b) equals -cos(a) exactly.
- R8: The folded angle that enters the first rotation lies in [0, 1/4] half-turn. The results at the fold edge, codes 2^(W-3)-1 and 2^(W-3), meet R3.
- R9: The residual angle after each rotation fits the narrowed width of the next rotation, and after the last rotation it is smaller than 2^-(W+1) half-turn in magnitude. Accuracy over the whole input range shows that no residual was lost.
- R10: For input codes with the sign bit clear, `sin_out` is never negative. With the sign bit set, it is never positive.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ang_vld | input | 1 | Angle on `ang` is to be processed this cycle |
| ang | input | W | Angle in half-turns, two's complement, W-1 fraction bits |
| res_vld | output | 1 | `sin_out` and `cos_out` hold a result |
| sin_out | output | W | Scaled sine, signed, W-1 fraction bits |
| cos_out | output | W | Scaled cosine, signed, W-1 fraction bits |

## Verification
The hardest case to reach from the ports is a residual angle that nearly overflows its narrowed width, or rounding that piles up close to one output code. Only a few angles come near these limits, and nothing at the ports tells which ones. The stimulus therefore streams every one of the 2^W input codes back to back and compares each result against a real-valued reference. The stored results are then used to check the exact swap and negation relations across eighths, quarters and half-turns, plus the four axis angles where the result must hit full scale or zero exactly.

// File: rtl/sincos_pkg.sv
package sincos_pkg;

  localparam real PI_VAL = 3.14159265358979323846;

  // Sector bits carried alongside the datapath to the output stage
  typedef struct packed {
    logic neg_half;
    logic upper_q;
    logic odd_oct;
  } sector_t;

  // Guard bits so that the accumulated truncation over all stages stays
  // well under a quarter of an output code
  function automatic int guard_bits(int stages);
    return $clog2(stages) + 3;
  endfunction

  // Width of the residual angle entering rotation idx (idx starts at 1)
  function automatic int z_width(int zfrac, int idx);
    return zfrac + 3 - idx;
  endfunction

  // atan(2^-idx) expressed in half-turns, zfrac fraction bits, rounded
  function automatic longint atan_code(int idx, int zfrac);
    real a;
    a = $atan(2.0 ** (-idx)) / PI_VAL;
    return longint'(a * (2.0 ** zfrac));
  endfunction

  // Start value of the cosine register: inverse rotation gain times the
  // output full-scale factor, fi fraction bits, rounded
  function automatic longint gain_code(int stages, int frac_out, int fi);
    real k;
    k = 1.0;
    for (int i = 1; i <= stages; i++) begin
      k = k / $sqrt(1.0 + 2.0 ** (-2 * i));
    end
    k = k * (1.0 - 2.0 ** (-frac_out));
    return longint'(k * (2.0 ** fi));
  endfunction

endpackage

// File: rtl/sincos_fold.sv
module sincos_fold
  import sincos_pkg::*;
#(
  parameter int W  = 16,
  parameter int GB = 8,
  parameter int ZW = 25
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_vld,
  input  logic [W-1:0]         in_ang,
  output logic                 out_vld,
  output sector_t              out_sect,
  output logic signed [ZW-1:0] out_z
);

  localparam int YW = W - 2;
  localparam int PAD = ZW - YW - GB;
  localparam logic [YW-1:0] QTR_CODE = {1'b1, {(YW-1){1'b0}}};
  localparam int ZF = W - 1 + GB;
  localparam logic signed [ZW-1:0] QTR_Z = {{(ZW-ZF+1){1'b0}}, 1'b1, {(ZF-2){1'b0}}};

  logic [YW-1:0]         y_low;
  logic [YW-1:0]         y_fold;
  sector_t               sect_nx;
  logic signed [ZW-1:0]  z_nx;

  always_comb begin
    sect_nx.neg_half = in_ang[W-1];
    sect_nx.upper_q  = in_ang[W-2];
    sect_nx.odd_oct  = in_ang[W-3];
    y_low  = {1'b0, in_ang[W-4:0]};
    y_fold = sect_nx.odd_oct ? (QTR_CODE - y_low) : y_low;
    z_nx   = {{PAD{1'b0}}, y_fold, {GB{1'b0}}};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_vld <= 1'b0;
    end else begin
      out_vld <= in_vld;
    end
  end

  always_ff @(posedge clk) begin
    if (in_vld) begin
      out_sect <= sect_nx;
      out_z    <= z_nx;
    end
  end

  // R8
  fold_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |-> (!out_z[ZW-1] && (out_z <= QTR_Z)));

endmodule

// File: rtl/sincos_rot_stage.sv
module sincos_rot_stage
  import sincos_pkg::*;
#(
  parameter int IDX = 1,
  parameter int DW  = 25,
  parameter int ZWI = 25,
  parameter int ZWO = 24,
  parameter int ZF  = 23
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_vld,
  input  sector_t               in_sect,
  input  logic signed [DW-1:0]  in_c,
  input  logic signed [DW-1:0]  in_s,
  input  logic signed [ZWI-1:0] in_z,
  output logic                  out_vld,
  output sector_t               out_sect,
  output logic signed [DW-1:0]  out_c,
  output logic signed [DW-1:0]  out_s,
  output logic signed [ZWO-1:0] out_z
);

  localparam logic signed [ZWI-1:0] ATAN_K = ZWI'(atan_code(IDX, ZF));

  logic                  rot_pos;
  logic signed [DW-1:0]  c_sh;
  logic signed [DW-1:0]  s_sh;
  logic signed [DW-1:0]  c_nx;
  logic signed [DW-1:0]  s_nx;
  logic signed [ZWI-1:0] z_full;
  logic signed [ZWO-1:0] z_nx;

  always_comb begin
    rot_pos = !in_z[ZWI-1] && (in_z != '0);
    c_sh    = in_c >>> IDX;
    s_sh    = in_s >>> IDX;
    if (rot_pos) begin
      c_nx   = in_c - s_sh;
      s_nx   = in_s + c_sh;
      z_full = in_z - ATAN_K;
    end else begin
      c_nx   = in_c + s_sh;
      s_nx   = in_s - c_sh;
      z_full = in_z + ATAN_K;
    end
    z_nx = z_full[ZWO-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_vld <= 1'b0;
    end else begin
      out_vld <= in_vld;
    end
  end

  always_ff @(posedge clk) begin
    if (in_vld) begin
      out_sect <= in_sect;
      out_c    <= c_nx;
      out_s    <= s_nx;
      out_z    <= z_nx;
    end
  end

  // R9
  z_narrow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld |-> ((z_full[ZWI-1:ZWO-1] == '0) || (z_full[ZWI-1:ZWO-1] == '1)));

endmodule

// File: rtl/sincos_rebuild.sv
module sincos_rebuild
  import sincos_pkg::*;
#(
  parameter int W  = 16,
  parameter int DW = 25,
  parameter int GB = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_vld,
  input  sector_t              in_sect,
  input  logic signed [DW-1:0] in_c,
  input  logic signed [DW-1:0] in_s,
  output logic                 out_vld,
  output logic signed [W-1:0]  sin_o,
  output logic signed [W-1:0]  cos_o
);

  localparam int FO = W - 1;
  localparam logic signed [DW-1:0] HALF_LSB = {{(DW-GB){1'b0}}, 1'b1, {(GB-1){1'b0}}};
  localparam logic signed [DW-1:0] POS_MAX  = {{(DW-FO){1'b0}}, {FO{1'b1}}};
  localparam logic signed [DW-1:0] NEG_MAX  = -POS_MAX;
  localparam logic signed [W-1:0]  MIN_CODE = {1'b1, {(W-1){1'b0}}};

  function automatic logic signed [W-1:0] round_sat(input logic signed [DW-1:0] v);
    logic signed [DW-1:0] r;
    r = (v + HALF_LSB) >>> GB;
    if (r > POS_MAX) begin
      r = POS_MAX;
    end else if (r < NEG_MAX) begin
      r = NEG_MAX;
    end
    return r[W-1:0];
  endfunction

  logic signed [W-1:0] c_rnd;
  logic signed [W-1:0] s_rnd;
  logic signed [W-1:0] a_sel;
  logic signed [W-1:0] b_sel;
  logic signed [W-1:0] sin_nx;
  logic signed [W-1:0] cos_nx;
  logic                swap;

  always_comb begin
    c_rnd  = round_sat(in_c);
    s_rnd  = round_sat(in_s);
    swap   = in_sect.upper_q ^ in_sect.odd_oct;
    a_sel  = swap ? c_rnd : s_rnd;
    b_sel  = swap ? s_rnd : c_rnd;
    sin_nx = in_sect.neg_half ? -a_sel : a_sel;
    cos_nx = (in_sect.neg_half ^ in_sect.upper_q) ? -b_sel : b_sel;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_vld <= 1'b0;
    end else begin
      out_vld <= in_vld;
    end
  end

  always_ff @(posedge clk) begin
    if (in_vld) begin
      sin_o <= sin_nx;
      cos_o <= cos_nx;
    end
  end

  // R4
  no_min_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |-> ((sin_o != MIN_CODE) && (cos_o != MIN_CODE)));

  // R10
  sin_sign_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && !in_sect.neg_half) |=> !sin_o[W-1]);

  // R10
  sin_sign_neg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && in_sect.neg_half) |=> (sin_o[W-1] || (sin_o == '0)));

endmodule

// File: rtl/sincos_cordic_pipe.sv
module sincos_cordic_pipe
  import sincos_pkg::*;
#(
  parameter int W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ang_vld,
  input  logic [W-1:0]        ang,
  output logic                res_vld,
  output logic signed [W-1:0] sin_out,
  output logic signed [W-1:0] cos_out
);

  localparam int FO  = W - 1;
  localparam int NST = W + 1;
  localparam int GB  = guard_bits(NST);
  localparam int FI  = FO + GB;
  localparam int DW  = FI + 2;
  localparam int ZW0 = z_width(FI, 1);
  localparam int ZWL = z_width(FI, NST + 1);
  localparam logic signed [DW-1:0]  C_INIT = DW'(gain_code(NST, FO, FI));
  localparam logic signed [ZWL-1:0] Z_LIM  = {2'b01, {(ZWL-2){1'b0}}};

  logic                 vld_p [0:NST];
  sector_t              sec_p [0:NST];
  logic signed [DW-1:0] c_p   [0:NST];
  logic signed [DW-1:0] s_p   [0:NST];
  logic signed [ZW0-1:0] z0;

  sincos_fold #(.W(W), .GB(GB), .ZW(ZW0)) i_fold (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_vld   (ang_vld),
    .in_ang   (ang),
    .out_vld  (vld_p[0]),
    .out_sect (sec_p[0]),
    .out_z    (z0)
  );

  assign c_p[0] = C_INIT;
  assign s_p[0] = '0;

  for (genvar k = 1; k <= NST; k++) begin : g_rot
    localparam int ZI = z_width(FI, k);
    localparam int ZO = z_width(FI, k + 1);
    logic signed [ZI-1:0] z_in;
    logic signed [ZO-1:0] z_out;

    if (k == 1) begin : g_first
      assign z_in = z0;
    end else begin : g_next
      assign z_in = g_rot[k-1].z_out;
    end

    sincos_rot_stage #(.IDX(k), .DW(DW), .ZWI(ZI), .ZWO(ZO), .ZF(FI)) i_stage (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_vld   (vld_p[k-1]),
      .in_sect  (sec_p[k-1]),
      .in_c     (c_p[k-1]),
      .in_s     (s_p[k-1]),
      .in_z     (z_in),
      .out_vld  (vld_p[k]),
      .out_sect (sec_p[k]),
      .out_c    (c_p[k]),
      .out_s    (s_p[k]),
      .out_z    (z_out)
    );
  end

  sincos_rebuild #(.W(W), .DW(DW), .GB(GB)) i_rebuild (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_vld   (vld_p[NST]),
    .in_sect  (sec_p[NST]),
    .in_c     (c_p[NST]),
    .in_s     (s_p[NST]),
    .out_vld  (res_vld),
    .sin_o    (sin_out),
    .cos_o    (cos_out)
  );

  logic signed [ZWL-1:0] z_last;
  assign z_last = g_rot[NST].z_out;

  // R9
  residual_small_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vld_p[NST] |-> ((z_last < Z_LIM) && (z_last > -Z_LIM)));

endmodule

// File: tb/test_sincos_cordic_pipe.sv
module test_sincos_cordic_pipe;

  localparam int  W          = 16;
  localparam int  F          = W - 1;
  localparam int  LAT        = W + 3;
  localparam int  CLK_PERIOD = 10;
  localparam int  WDOG       = 150000;
  localparam int  NCODE      = 2 ** W;
  localparam int  FULL       = 2 ** F - 1;
  localparam real PI_R       = 3.14159265358979323846;

  logic                clk;
  logic                rst_n;
  logic                ang_vld;
  logic [W-1:0]        ang;
  logic                res_vld;
  logic signed [W-1:0] sin_out;
  logic signed [W-1:0] cos_out;

  int n_chk;
  int n_bad;
  int cyc;
  int sweep_bad;
  bit finished;

  int q_ang[$];
  int q_t[$];
  int sin_tab [int];
  int cos_tab [int];

  int  m_a;
  int  m_t;
  int  m_sv;
  int  m_cv;
  real m_x;
  real m_rs;
  real m_rc;

  sincos_cordic_pipe #(.W(W)) i_sincos_cordic_pipe (
    .clk     (clk),
    .rst_n   (rst_n),
    .ang_vld (ang_vld),
    .ang     (ang),
    .res_vld (res_vld),
    .sin_out (sin_out),
    .cos_out (cos_out)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  initial cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string detail);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s", req, detail);
    end
  endtask

  function automatic real code_val(input int a);
    int v;
    v = (a >= 2 ** (W - 1)) ? a - NCODE : a;
    return real'(v) / real'(2 ** F);
  endfunction

  function automatic real absr(input real v);
    return (v < 0.0) ? -v : v;
  endfunction

  // Monitor: ordering, latency, accuracy, code range, sine sign
  always @(negedge clk) begin
    if (rst_n && res_vld) begin
      if (q_ang.size() == 0) begin
        chk(1'b0, "R2", "result without accepted angle: actual=valid expected=idle");
      end else begin
        m_a  = q_ang.pop_front();
        m_t  = q_t.pop_front();
        m_sv = int'(sin_out);
        m_cv = int'(cos_out);
        chk(cyc - m_t == LAT, "R2",
            $sformatf("latency for code %0d actual=%0d expected=%0d", m_a, cyc - m_t, LAT));
        m_x  = code_val(m_a);
        m_rs = real'(FULL) * $sin(PI_R * m_x);
        m_rc = real'(FULL) * $cos(PI_R * m_x);
        if (absr(real'(m_sv) - m_rs) >= 1.0 || absr(real'(m_cv) - m_rc) >= 1.0) begin
          sweep_bad++;
        end
        chk(absr(real'(m_sv) - m_rs) < 1.0, "R3",
            $sformatf("sin code %0d actual=%0d expected=%0.3f", m_a, m_sv, m_rs));
        chk(absr(real'(m_cv) - m_rc) < 1.0, "R3",
            $sformatf("cos code %0d actual=%0d expected=%0.3f", m_a, m_cv, m_rc));
        chk((m_sv != -(2 ** F)) && (m_cv != -(2 ** F)), "R4",
            $sformatf("code %0d actual sin=%0d cos=%0d expected neither %0d", m_a, m_sv, m_cv, -(2 ** F)));
        if (m_a < 2 ** (W - 1)) begin
          chk(m_sv >= 0, "R10", $sformatf("code %0d actual sin=%0d expected >= 0", m_a, m_sv));
        end else begin
          chk(m_sv <= 0, "R10", $sformatf("code %0d actual sin=%0d expected <= 0", m_a, m_sv));
        end
        sin_tab[m_a] = m_sv;
        cos_tab[m_a] = m_cv;
      end
    end
  end

  task automatic send(input int a);
    @(negedge clk);
    ang_vld = 1'b1;
    ang     = W'(a);
    q_ang.push_back(a);
    q_t.push_back(cyc);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      ang_vld = 1'b0;
    end
  endtask

  task automatic drain();
    idle(LAT + 3);
    chk(q_ang.size() == 0, "R2",
        $sformatf("pending results actual=%0d expected=0", q_ang.size()));
  endtask

  // R1: output valid stays low in reset and after it with no input
  task automatic t_reset();
    rst_n   = 1'b1;
    ang_vld = 1'b0;
    ang     = '0;
    #1 rst_n = 1'b0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(res_vld == 1'b0, "R1", $sformatf("in reset actual=%0b expected=0", res_vld));
    end
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < LAT + 2; i++) begin
      @(negedge clk);
      chk(res_vld == 1'b0, "R1", $sformatf("after reset, idle actual=%0b expected=0", res_vld));
    end
  endtask

  // R2: single angle and a stream with idle gaps
  task automatic t_gaps();
    send(1234);
    idle(LAT + 4);
    for (int k = 0; k < 15; k++) begin
      send((k * 4099 + 77) % NCODE);
      if (k % 3 == 0) idle(1);
      if (k % 5 == 4) idle(2);
    end
    drain();
  endtask

  // R4: axis angles must be exact
  task automatic t_axes();
    int pts[4];
    int es[4];
    int ec[4];
    pts = '{0, 2 ** (W - 2), 2 ** (W - 1), 3 * 2 ** (W - 2)};
    es  = '{0, FULL, 0, -FULL};
    ec  = '{FULL, 0, -FULL, 0};
    for (int i = 0; i < 4; i++) send(pts[i]);
    drain();
    for (int i = 0; i < 4; i++) begin
      chk(sin_tab[pts[i]] == es[i], "R4",
          $sformatf("sin at code %0d actual=%0d expected=%0d", pts[i], sin_tab[pts[i]], es[i]));
      chk(cos_tab[pts[i]] == ec[i], "R4",
          $sformatf("cos at code %0d actual=%0d expected=%0d", pts[i], cos_tab[pts[i]], ec[i]));
    end
  endtask

  // R3, R9: every code streamed back to back
  task automatic t_sweep();
    sweep_bad = 0;
    for (int a = 0; a < NCODE; a++) send(a);
    drain();
    chk(sweep_bad == 0, "R9",
        $sformatf("inaccurate codes in full sweep actual=%0d expected=0", sweep_bad));
    chk(sin_tab.num() == NCODE, "R3",
        $sformatf("results collected actual=%0d expected=%0d", sin_tab.num(), NCODE));
  endtask

  // R8: fold edge on both sides
  task automatic t_fold_edge();
    int lo;
    int hi;
    lo = 2 ** (W - 3) - 1;
    hi = 2 ** (W - 3);
    chk(absr(real'(sin_tab[lo]) - real'(FULL) * $sin(PI_R * code_val(lo))) < 1.0, "R8",
        $sformatf("sin below edge actual=%0d", sin_tab[lo]));
    chk(absr(real'(cos_tab[hi]) - real'(FULL) * $cos(PI_R * code_val(hi))) < 1.0, "R8",
        $sformatf("cos at edge actual=%0d", cos_tab[hi]));
    chk(absr(real'(sin_tab[hi]) - real'(FULL) * $sin(PI_R * code_val(hi))) < 1.0, "R8",
        $sformatf("sin at edge actual=%0d", sin_tab[hi]));
  endtask

  // R5: eighth mirror
  task automatic t_octant();
    int bad;
    bad = 0;
    for (int a = 1; a < 2 ** (W - 3); a++) begin
      int b;
      b = 2 ** (W - 2) - a;
      if (sin_tab[b] != cos_tab[a] || cos_tab[b] != sin_tab[a]) begin
        if (bad == 0)
          $display("FAIL R5 code %0d actual sin=%0d cos=%0d expected sin=%0d cos=%0d",
                   b, sin_tab[b], cos_tab[b], cos_tab[a], sin_tab[a]);
        bad++;
      end
    end
    n_chk++;
    if (bad != 0) n_bad++;
  endtask

  // R6: quarter step
  task automatic t_quarter();
    int bad;
    bad = 0;
    for (int a = 0; a < 2 ** (W - 2); a++) begin
      int b;
      b = a + 2 ** (W - 2);
      if (sin_tab[b] != cos_tab[a] || cos_tab[b] != -sin_tab[a]) begin
        if (bad == 0)
          $display("FAIL R6 code %0d actual sin=%0d cos=%0d expected sin=%0d cos=%0d",
                   b, sin_tab[b], cos_tab[b], cos_tab[a], -sin_tab[a]);
        bad++;
      end
    end
    n_chk++;
    if (bad != 0) n_bad++;
  endtask

  // R7: half-turn negation
  task automatic t_half();
    int bad;
    bad = 0;
    for (int a = 0; a < 2 ** (W - 1); a++) begin
      int b;
      b = a + 2 ** (W - 1);
      if (sin_tab[b] != -sin_tab[a] || cos_tab[b] != -cos_tab[a]) begin
        if (bad == 0)
          $display("FAIL R7 code %0d actual sin=%0d cos=%0d expected sin=%0d cos=%0d",
                   b, sin_tab[b], cos_tab[b], -sin_tab[a], -cos_tab[a]);
        bad++;
      end
    end
    n_chk++;
    if (bad != 0) n_bad++;
  endtask

  initial begin
    n_chk    = 0;
    n_bad    = 0;
    finished = 1'b0;
    t_reset();
    t_gaps();
    t_axes();
    t_sweep();
    t_fold_edge();
    t_octant();
    t_quarter();
    t_half();
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (WDOG) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL R2 watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

endmodule